// File: doc/BRIEF.md
# GPIO Pin-Function Configuration Unit

This block holds the configuration of up to sixteen general-purpose pins and decides which pin carries each special function. A host does not see the configuration bytes directly. It reaches them through one 16-bit window: every write to the window carries a 7-bit internal byte address and a data byte. A strobe bit in the same word says whether the byte is stored or whether only the address pointer is loaded. A read of the window returns the byte at the current pointer.

Each pin has a direction bit, a data bit and a 3-bit function field. Function fields sit two to a byte. From these fields the unit builds one select vector per special function: trigger out, event request, external clock, receive clock 0 and receive clock 1. If several pins ask for the same function, the pin with the lowest index gets it. Every other pin that asks for it acts as a plain GPIO. Pad levels pass through a two-stage synchronizer before they can be read back.

Top module: `gpio_pinmux_cfg`

## Requirements
- R1: A window write with bit 15 clear loads the pointer from bits [14:8] and changes no stored configuration byte.
- R2: A window write with bit 15 set stores bits [7:0] at address bits [14:8] and loads the pointer with that address. The window reads back the pointed byte in [7:0], with bits [15:8] always zero.
- R3: Pin p's direction bit is bit p%8 of address 0x62+p/8. Value 0 makes the pin an output, so pad_oe[p] is 1; value 1 makes it an input, so pad_oe[p] is 0.
- R4: Pin p's data bit is bit p%8 of address 0x64+p/8 and drives pad_out[p]. For an output pin, a read of that bit returns the stored value.
- R5: For an input pin, a read of its data bit returns pad_in[p] as it was two clock edges earlier.
- R6: Pin p's function field sits at address 0x68+p/2, in bits [2:0] for even p and bits [6:4] for odd p. Bits 3 and 7 of these bytes read as zero.
- R7: Function codes are 1 trigger out, 2 event request, 3 external clock, 4 receive clock 0 and 5 receive clock 1. fn_sel bits [(c-1)*NPIN +: NPIN] form the select vector for code c. That vector marks only the lowest-index pin holding code c, or no pin if none holds it.
- R8: Codes 0, 6 and 7 select no function for that pin.
- R9: Direction, data and function bits of pins at or above NPIN read as zero and ignore writes.
- R10: Addresses 0x60 and 0x61 are full 8-bit read/write bytes.
- R11: After reset, the pointer is 0, every implemented pin is an input, and all data bits, function fields and bytes 0x60/0x61 are zero.
- R12: Any address outside 0x60–0x65 and 0x68–0x6F reads as zero, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_wr | input | 1 | Window write enable |
| win_wdata | input | 16 | Bit 15 store strobe, [14:8] byte address, [7:0] data |
| win_rdata | output | 16 | Byte at current pointer in [7:0], upper byte zero |
| pad_in | input | NPIN | Pad levels, asynchronous |
| pad_oe | output | NPIN | Output enable per pin |
| pad_out | output | NPIN | Output value per pin |
| fn_sel | output | 5*NPIN | One select vector per function code 1..5 |

## Verification
The hardest case to reach from the ports is contention: two pins holding the same function code. The bench must then observe a hand-over when the winning pin releases it. Function fields are packed two per byte, so releasing one pin means rewriting its shared byte, which can disturb the neighbouring pin's field. The stimulus writes whole bytes with a reserved code in the neighbour slot, so one write both releases the lower winner and proves that the reserved code selects nothing. It then checks that the higher claimant takes over. It also writes to byte slots of pins above NPIN and confirms that the implemented neighbour is untouched.

// File: rtl/gpcfg_pkg.sv
package gpcfg_pkg;
  localparam int NFUNC = 5;
  localparam int FW    = 3;
  localparam logic [6:0] A_CFG0 = 7'h60;
  localparam logic [6:0] A_CFG1 = 7'h61;
  localparam logic [6:0] A_DIR  = 7'h62;
  localparam logic [6:0] A_DAT  = 7'h64;
  localparam logic [6:0] A_MODE = 7'h68;

  function automatic logic [6:0] dir_addr(input int p);
    return A_DIR + 7'(p / 8);
  endfunction

  function automatic logic [6:0] dat_addr(input int p);
    return A_DAT + 7'(p / 8);
  endfunction

  function automatic logic [6:0] mode_addr(input int p);
    return A_MODE + 7'(p / 2);
  endfunction

  function automatic int mode_lsb(input int p);
    return (p % 2 == 1) ? 4 : 0;
  endfunction

  function automatic logic is_mapped(input logic [6:0] a);
    return ((a >= 7'h60) && (a <= 7'h65)) || ((a >= 7'h68) && (a <= 7'h6F));
  endfunction

  function automatic logic is_active(input logic [FW-1:0] m);
    return (m >= 3'd1) && (m <= 3'(NFUNC));
  endfunction
endpackage

// File: rtl/gpcfg_sync.sv
module gpcfg_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= {st[STAGES-2:0], din};
  end

  assign dout = st[STAGES-1];
endmodule

// File: rtl/gpcfg_regbank.sv
module gpcfg_regbank
  import gpcfg_pkg::*;
#(
  parameter int NPIN = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     win_wr,
  input  logic [15:0]              win_wdata,
  input  logic [NPIN-1:0]          pad_sync,
  output logic [7:0]               rd_byte,
  output logic [NPIN-1:0]          dir_q,
  output logic [NPIN-1:0]          dat_q,
  output logic [NPIN-1:0][FW-1:0]  mode_q
);
  logic [6:0]      ptr_q;
  logic [1:0][7:0] cfg_q;
  logic [6:0]      waddr;
  logic [7:0]      wbyte;
  logic            wstore;

  assign waddr  = win_wdata[14:8];
  assign wbyte  = win_wdata[7:0];
  assign wstore = win_wr && win_wdata[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      cfg_q  <= '0;
      dir_q  <= '1;
      dat_q  <= '0;
      mode_q <= '0;
    end else begin
      if (win_wr) ptr_q <= waddr;
      if (wstore) begin
        if (waddr == A_CFG0) cfg_q[0] <= wbyte;
        if (waddr == A_CFG1) cfg_q[1] <= wbyte;
        for (int p = 0; p < NPIN; p++) begin
          if (waddr == dir_addr(p))  dir_q[p]  <= wbyte[3'(p % 8)];
          if (waddr == dat_addr(p))  dat_q[p]  <= wbyte[3'(p % 8)];
          if (waddr == mode_addr(p)) mode_q[p] <= wbyte[mode_lsb(p) +: FW];
        end
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    if (ptr_q == A_CFG0) rd_byte = cfg_q[0];
    if (ptr_q == A_CFG1) rd_byte = cfg_q[1];
    for (int p = 0; p < NPIN; p++) begin
      if (ptr_q == dir_addr(p))  rd_byte[3'(p % 8)] = dir_q[p];
      if (ptr_q == dat_addr(p))  rd_byte[3'(p % 8)] = dir_q[p] ? pad_sync[p] : dat_q[p];
      if (ptr_q == mode_addr(p)) rd_byte[mode_lsb(p) +: FW] = mode_q[p];
    end
  end

  AST_PTR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && !win_wdata[15]) |=> ($stable(cfg_q) && $stable(dir_q) && $stable(dat_q) && $stable(mode_q))); // R1
  AST_CFG_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wstore && waddr == A_CFG0) |=> (rd_byte == $past(wbyte))); // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mapped(ptr_q) |-> (rd_byte == 8'h00)); // R12
endmodule

// File: rtl/gpcfg_arbiter.sv
module gpcfg_arbiter
  import gpcfg_pkg::*;
#(
  parameter int NPIN = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPIN-1:0][FW-1:0]  mode_q,
  output logic [NFUNC*NPIN-1:0]    fn_sel
);
  logic [NPIN-1:0] pin_busy;

  for (genvar gf = 0; gf < NFUNC; gf++) begin : g_fn
    logic [NPIN-1:0] win;
    always_comb begin
      logic taken;
      taken = 1'b0;
      win   = '0;
      for (int p = 0; p < NPIN; p++) begin
        if (!taken && mode_q[p] == 3'(gf + 1)) begin
          win[p] = 1'b1;
          taken  = 1'b1;
        end
      end
    end
    assign fn_sel[gf*NPIN +: NPIN] = win;

    AST_FN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fn_sel[gf*NPIN +: NPIN])); // R7
  end

  always_comb begin
    pin_busy = '0;
    for (int f = 0; f < NFUNC; f++) pin_busy = pin_busy | fn_sel[f*NPIN +: NPIN];
  end

  for (genvar gp = 0; gp < NPIN; gp++) begin : g_pin
    AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !is_active(mode_q[gp]) |-> !pin_busy[gp]); // R8
  end
endmodule

// File: rtl/gpio_pinmux_cfg.sv
module gpio_pinmux_cfg
  import gpcfg_pkg::*;
#(
  parameter int NPIN        = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  win_wr,
  input  logic [15:0]           win_wdata,
  output logic [15:0]           win_rdata,
  input  logic [NPIN-1:0]       pad_in,
  output logic [NPIN-1:0]       pad_oe,
  output logic [NPIN-1:0]       pad_out,
  output logic [NFUNC*NPIN-1:0] fn_sel
);
  logic [NPIN-1:0]         pad_sync;
  logic [7:0]              rd_byte;
  logic [NPIN-1:0]         dir_q;
  logic [NPIN-1:0]         dat_q;
  logic [NPIN-1:0][FW-1:0] mode_q;

  gpcfg_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pad_sync)
  );

  gpcfg_regbank #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .win_wr(win_wr), .win_wdata(win_wdata),
    .pad_sync(pad_sync), .rd_byte(rd_byte), .dir_q(dir_q), .dat_q(dat_q),
    .mode_q(mode_q)
  );

  gpcfg_arbiter #(.NPIN(NPIN)) u_arb (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .fn_sel(fn_sel)
  );

  assign win_rdata = {8'h00, rd_byte};
  assign pad_oe    = ~dir_q;
  assign pad_out   = dat_q;
endmodule

// File: tb/sim_gpio_pinmux_cfg.sv
module sim_gpio_pinmux_cfg;
  localparam int NPIN = 11;
  localparam int FSW  = 5 * NPIN;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            win_wr = 1'b0;
  logic [15:0]     win_wdata = '0;
  logic [15:0]     win_rdata;
  logic [NPIN-1:0] pad_in = '0;
  logic [NPIN-1:0] pad_oe;
  logic [NPIN-1:0] pad_out;
  logic [FSW-1:0]  fn_sel;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  gpio_pinmux_cfg #(.NPIN(NPIN)) u0 (
    .clk(clk), .rst_n(rst_n), .win_wr(win_wr), .win_wdata(win_wdata),
    .win_rdata(win_rdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .fn_sel(fn_sel)
  );

  // {address, data written with strobe, expected read-back byte}
  localparam int NVEC = 8;
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h60, 8'hA5, 8'hA5},   // R10
    {8'h61, 8'h3C, 8'h3C},   // R10
    {8'h68, 8'hFF, 8'h77},   // R6 bits 3 and 7 read zero
    {8'h6D, 8'h9B, 8'h03},   // R9 pin 11 slot unimplemented
    {8'h6E, 8'h55, 8'h00},   // R9 pins 12/13
    {8'h63, 8'hFF, 8'h07},   // R9 dir pins 11..15
    {8'h66, 8'hFF, 8'h00},   // R12
    {8'h70, 8'h12, 8'h00}    // R12
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] w);
    @(negedge clk);
    win_wr = 1'b1;
    win_wdata = w;
    @(negedge clk);
    win_wr = 1'b0;
    win_wdata = '0;
  endtask

  task automatic store(input logic [6:0] a, input logic [7:0] d);
    wr({1'b1, a, d});
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    wr({1'b0, a, 8'h00});
    d = win_rdata[7:0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [63:0] fbit(input int code, input int pin);
    return 64'(1) << ((code - 1) * NPIN + pin);
  endfunction

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b;
    do_reset();

    foreach (VEC[i]) begin
      store(VEC[i][22:16], VEC[i][15:8]);
      rd(VEC[i][22:16], b);
      check($sformatf("R2/R6/R9/R10/R12 vec%0d", i), 64'(b), 64'(VEC[i][7:0]));
      check("R2 upper byte", 64'(win_rdata[15:8]), 64'h0);
    end

    // R11 reset state
    do_reset();
    check("R11 pointer/cfg0", 64'(win_rdata), 64'h0);
    rd(7'h62, b); check("R11 dir lo", 64'(b), 64'hFF);
    rd(7'h63, b); check("R11 dir hi", 64'(b), 64'h07);
    rd(7'h68, b); check("R11 mode", 64'(b), 64'h00);
    rd(7'h61, b); check("R11 cfg1", 64'(b), 64'h00);
    check("R11 oe", 64'(pad_oe), 64'h0);
    check("R11 fn", 64'(fn_sel), 64'h0);

    // R1 pointer-only write does not store
    store(7'h60, 8'h11);
    wr({1'b0, 7'h60, 8'hEE});
    check("R1 no store", 64'(win_rdata), 64'h11);

    // R3 / R4 direction and output data
    store(7'h62, 8'hFE);
    store(7'h64, 8'h01);
    check("R3 oe", 64'(pad_oe), 64'h001);
    check("R4 out", 64'(pad_out[0]), 64'h1);

    // R5 input read via synchronizer; output pin reads stored value
    @(negedge clk);
    pad_in = 11'h002;
    @(negedge clk);
    rd(7'h64, b);
    check("R5 R4 data read", 64'(b), 64'h03);
    pad_in = 11'h000;
    repeat (3) @(negedge clk);
    rd(7'h64, b);
    check("R5 pad low", 64'(b), 64'h01);

    // R7 contention: pin0 code4, pin3 code1, pin5 code1
    store(7'h68, 8'h04);
    store(7'h69, 8'h10);
    store(7'h6A, 8'h10);
    check("R7 lowest wins", 64'(fn_sel), fbit(1, 3) | fbit(4, 0));
    // R8 pin2 reserved code 6 with pin3 released; pin5 takes over
    store(7'h69, 8'h06);
    check("R7 R8 handover", 64'(fn_sel), fbit(1, 5) | fbit(4, 0));
    // R9 top implemented pin 10, event request, odd slot write ignored
    store(7'h6D, 8'h72);
    check("R7 R9 pin10", 64'(fn_sel), fbit(1, 5) | fbit(4, 0) | fbit(2, 10));
    rd(7'h6D, b); check("R9 slot", 64'(b), 64'h02);
    // R8 code 7 and code 0 release everything
    store(7'h68, 8'h70);
    store(7'h6A, 8'h07);
    store(7'h6D, 8'h00);
    check("R8 idle", 64'(fn_sel), 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule